// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the control unit of a single-cycle 32-bit processor with a small load/store instruction subset. It looks at the 6-bit opcode field and the 6-bit function field of the current instruction and, with no clock and no state, drives every control point of the datapath. Those control points are the write-back register choice, the register-file write enable, the ALU second-operand choice, the ALU operation, the immediate extender mode, the write-back source, the data-memory write enable and the next-PC choice.

The supported instructions are three register-format operations (add, subtract, OR), an OR with an immediate, load word, store word and branch-if-equal. Any other opcode, and any register-format function code outside the three supported ones, yields a safe setting. In that setting nothing is written and the PC advances by one instruction. Internally the opcode and the function code are each reduced to a small class. A control-word stage then turns the pair into the output bits.

Top module: `main_ctrl_dec`

## Requirements
Output encodings: `alu_op` 2'b00 = add, 2'b01 = subtract, 2'b10 = OR; `ext_sign` 0 = zero-extend, 1 = sign-extend; `dst_rd` 0 = rt field, 1 = rd field; `alu_src_imm` 0 = second register, 1 = extended immediate; `wb_from_mem` 0 = ALU result, 1 = memory data; `npc_branch` 0 = PC+4, 1 = branch target. Any output not listed for an instruction is 0.

- R1: Opcode 000000 with funct 100000 (add) gives dst_rd=1, reg_we=1, alu_src_imm=0, alu_op=00, mem_we=0, wb_from_mem=0, npc_branch=0.
- R2: Opcode 000000 with funct 100010 (subtract) gives the R1 setting except alu_op=01.
- R3: Opcode 000000 with funct 100101 (OR) gives the R1 setting except alu_op=10.
- R4: Opcode 001101 (immediate OR) gives dst_rd=0, reg_we=1, alu_src_imm=1, ext_sign=0, alu_op=10, wb_from_mem=0, mem_we=0, npc_branch=0.
- R5: Opcode 100011 (load word) gives dst_rd=0, reg_we=1, alu_src_imm=1, ext_sign=1, alu_op=00, wb_from_mem=1, mem_we=0, npc_branch=0.
- R6: Opcode 101011 (store word) gives reg_we=0, alu_src_imm=1, ext_sign=1, alu_op=00, mem_we=1, npc_branch=0.
- R7: Opcode 000100 (branch-if-equal) gives alu_op=01, alu_src_imm=0, reg_we=0, mem_we=0, npc_branch=1.
- R8: Any opcode not named in R1-R7, and opcode 000000 with any funct other than the three in R1 to R3, gives reg_we=0, mem_we=0 and npc_branch=0, with every other output at 0.
- R9: For every non-zero opcode the funct field has no effect on any output.
- R10: reg_we and mem_we are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_op | input | 6 | Opcode field, instruction bits 31:26 |
| instr_fn | input | 6 | Function field, instruction bits 5:0 |
| dst_rd | output | 1 | Write-back register: 0 rt, 1 rd |
| reg_we | output | 1 | Register-file write enable |
| alu_src_imm | output | 1 | ALU second operand: 0 register, 1 immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |
| ext_sign | output | 1 | Extender: 0 zero-extend, 1 sign-extend |
| wb_from_mem | output | 1 | Write-back source: 0 ALU, 1 memory |
| mem_we | output | 1 | Data-memory write enable |
| npc_branch | output | 1 | Next PC: 0 PC+4, 1 branch target |

## Verification
The assertions check the cross-output rules whenever the inputs change: the two write enables are never both high, and a branch never writes and always subtracts. A memory write always takes a sign-extended immediate address, a memory write-back always comes with a register write, and an unrecognised opcode never writes or branches. Only the bench's scenarios can show that each supported instruction produces its exact control word. The same holds for the don't-care fields resting at 0 and for a funct value really being ignored under every non-register opcode. For these the bench sweeps all opcode and funct combinations against its own table.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    CLS_REG = 3'd0,
    CLS_ORI = 3'd1,
    CLS_LW  = 3'd2,
    CLS_SW  = 3'd3,
    CLS_BEQ = 3'd4,
    CLS_BAD = 3'd5
  } op_cls_e;

  typedef enum logic [1:0] {
    FNC_ADD = 2'd0,
    FNC_SUB = 2'd1,
    FNC_OR  = 2'd2,
    FNC_BAD = 2'd3
  } fn_cls_e;

  typedef struct packed {
    logic    dst_rd;
    logic    reg_we;
    logic    alu_src_imm;
    alu_op_e alu_op;
    logic    ext_sign;
    logic    wb_from_mem;
    logic    mem_we;
    logic    npc_branch;
  } ctrl_t;

  localparam ctrl_t CTRL_SAFE = '{
    dst_rd: 1'b0, reg_we: 1'b0, alu_src_imm: 1'b0, alu_op: ALU_ADD,
    ext_sign: 1'b0, wb_from_mem: 1'b0, mem_we: 1'b0, npc_branch: 1'b0
  };

endpackage

// File: rtl/mcd_op_class.sv
module mcd_op_class
  import mcd_pkg::*;
#(
  parameter int          OP_W    = 6,
  parameter logic [5:0]  OP_REG  = 6'b000000,
  parameter logic [5:0]  OP_ORI  = 6'b001101,
  parameter logic [5:0]  OP_LW   = 6'b100011,
  parameter logic [5:0]  OP_SW   = 6'b101011,
  parameter logic [5:0]  OP_BEQ  = 6'b000100
) (
  input  logic [OP_W-1:0] op,
  output op_cls_e         cls
);

  always_comb begin
    if      (op == OP_W'(OP_REG)) cls = CLS_REG;
    else if (op == OP_W'(OP_ORI)) cls = CLS_ORI;
    else if (op == OP_W'(OP_LW))  cls = CLS_LW;
    else if (op == OP_W'(OP_SW))  cls = CLS_SW;
    else if (op == OP_W'(OP_BEQ)) cls = CLS_BEQ;
    else                          cls = CLS_BAD;
  end

endmodule

// File: rtl/mcd_fn_class.sv
module mcd_fn_class
  import mcd_pkg::*;
#(
  parameter int         FN_W   = 6,
  parameter logic [5:0] FN_ADD = 6'b100000,
  parameter logic [5:0] FN_SUB = 6'b100010,
  parameter logic [5:0] FN_OR  = 6'b100101
) (
  input  logic [FN_W-1:0] fn,
  output fn_cls_e         cls
);

  always_comb begin
    unique case (fn)
      FN_W'(FN_ADD): cls = FNC_ADD;
      FN_W'(FN_SUB): cls = FNC_SUB;
      FN_W'(FN_OR):  cls = FNC_OR;
      default:       cls = FNC_BAD;
    endcase
  end

endmodule

// File: rtl/mcd_ctrl_word.sv
module mcd_ctrl_word
  import mcd_pkg::*;
(
  input  op_cls_e op_cls,
  input  fn_cls_e fn_cls,
  output ctrl_t   ctrl
);

  always_comb begin
    ctrl = CTRL_SAFE;
    unique case (op_cls)
      CLS_REG: begin
        if (fn_cls != FNC_BAD) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          unique case (fn_cls)
            FNC_SUB: ctrl.alu_op = ALU_SUB;
            FNC_OR:  ctrl.alu_op = ALU_OR;
            default: ctrl.alu_op = ALU_ADD;
          endcase
        end
      end
      CLS_ORI: begin
        ctrl.reg_we      = 1'b1;
        ctrl.alu_src_imm = 1'b1;
        ctrl.alu_op      = ALU_OR;
      end
      CLS_LW: begin
        ctrl.reg_we      = 1'b1;
        ctrl.alu_src_imm = 1'b1;
        ctrl.ext_sign    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      CLS_SW: begin
        ctrl.alu_src_imm = 1'b1;
        ctrl.ext_sign    = 1'b1;
        ctrl.mem_we      = 1'b1;
      end
      CLS_BEQ: begin
        ctrl.alu_op     = ALU_SUB;
        ctrl.npc_branch = 1'b1;
      end
      default: ctrl = CTRL_SAFE;
    endcase
  end

endmodule

// File: rtl/main_ctrl_dec.sv
module main_ctrl_dec
  import mcd_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6,
  localparam int ALU_W = $bits(alu_op_e)
) (
  input  logic [OP_W-1:0]  instr_op,
  input  logic [FN_W-1:0]  instr_fn,
  output logic             dst_rd,
  output logic             reg_we,
  output logic             alu_src_imm,
  output logic [ALU_W-1:0] alu_op,
  output logic             ext_sign,
  output logic             wb_from_mem,
  output logic             mem_we,
  output logic             npc_branch
);

  op_cls_e op_cls;
  fn_cls_e fn_cls;
  ctrl_t   ctrl;

  mcd_op_class #(.OP_W(OP_W)) u_op_class (
    .op  (instr_op),
    .cls (op_cls)
  );

  mcd_fn_class #(.FN_W(FN_W)) u_fn_class (
    .fn  (instr_fn),
    .cls (fn_cls)
  );

  mcd_ctrl_word u_ctrl_word (
    .op_cls (op_cls),
    .fn_cls (fn_cls),
    .ctrl   (ctrl)
  );

  assign dst_rd      = ctrl.dst_rd;
  assign reg_we      = ctrl.reg_we;
  assign alu_src_imm = ctrl.alu_src_imm;
  assign alu_op      = ctrl.alu_op;
  assign ext_sign    = ctrl.ext_sign;
  assign wb_from_mem = ctrl.wb_from_mem;
  assign mem_we      = ctrl.mem_we;
  assign npc_branch  = ctrl.npc_branch;

endmodule

// File: rtl/main_ctrl_dec_chk.sv
module main_ctrl_dec_chk #(
  parameter int OP_W  = 6,
  parameter int FN_W  = 6,
  parameter int ALU_W = 2
) (
  input logic [OP_W-1:0]  instr_op,
  input logic [FN_W-1:0]  instr_fn,
  input logic             dst_rd,
  input logic             reg_we,
  input logic             alu_src_imm,
  input logic [ALU_W-1:0] alu_op,
  input logic             ext_sign,
  input logic             wb_from_mem,
  input logic             mem_we,
  input logic             npc_branch
);

  logic op_known;
  logic unused_ok;

  always_comb begin
    op_known = (instr_op == OP_W'(6'b000000)) || (instr_op == OP_W'(6'b001101)) ||
               (instr_op == OP_W'(6'b100011)) || (instr_op == OP_W'(6'b101011)) ||
               (instr_op == OP_W'(6'b000100));
    unused_ok = ^{instr_fn, dst_rd};

    assert_one_writer_R10: assert (!(reg_we && mem_we))
      else $error("R10: register and memory writes both enabled");

    // R6: a memory write uses a sign-extended immediate address
    assert_store_addr_R6: assert (!mem_we || (alu_src_imm && ext_sign))
      else $error("R6: store without sign-extended immediate");

    // R7: the branch path never writes and always subtracts
    assert_branch_R7: assert (!npc_branch || (!reg_we && !mem_we && alu_op == ALU_W'(2'b01)))
      else $error("R7: branch with write or non-subtract");

    // R5: memory write-back only with a register write from rs + immediate
    assert_wbmem_R5: assert (!wb_from_mem || (reg_we && alu_src_imm && ext_sign))
      else $error("R5: memory write-back without load setting");

    assert_unknown_safe_R8: assert (op_known || (!reg_we && !mem_we && !npc_branch))
      else $error("R8: unknown opcode produced an action");
  end

endmodule

bind main_ctrl_dec main_ctrl_dec_chk #(
  .OP_W  (OP_W),
  .FN_W  (FN_W),
  .ALU_W (ALU_W)
) u_chk (
  .instr_op    (instr_op),
  .instr_fn    (instr_fn),
  .dst_rd      (dst_rd),
  .reg_we      (reg_we),
  .alu_src_imm (alu_src_imm),
  .alu_op      (alu_op),
  .ext_sign    (ext_sign),
  .wb_from_mem (wb_from_mem),
  .mem_we      (mem_we),
  .npc_branch  (npc_branch)
);

// File: tb/main_ctrl_dec_bench.sv
module main_ctrl_dec_bench;

  logic       clk;
  logic       rst_n;
  logic [5:0] instr_op;
  logic [5:0] instr_fn;
  logic       dst_rd, reg_we, alu_src_imm, ext_sign, wb_from_mem, mem_we, npc_branch;
  logic [1:0] alu_op;

  int n_cmp;
  int n_bad;
  bit done;

  main_ctrl_dec u_main_ctrl_dec (
    .instr_op    (instr_op),
    .instr_fn    (instr_fn),
    .dst_rd      (dst_rd),
    .reg_we      (reg_we),
    .alu_src_imm (alu_src_imm),
    .alu_op      (alu_op),
    .ext_sign    (ext_sign),
    .wb_from_mem (wb_from_mem),
    .mem_we      (mem_we),
    .npc_branch  (npc_branch)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // control word layout: {dst_rd, reg_we, alu_src_imm, alu_op[1:0], ext_sign, wb_from_mem, mem_we, npc_branch}
  function automatic logic [8:0] actual_word();
    return {dst_rd, reg_we, alu_src_imm, alu_op, ext_sign, wb_from_mem, mem_we, npc_branch};
  endfunction

  localparam logic [8:0] W_ADD = 9'b1_1_0_00_0_0_0_0;
  localparam logic [8:0] W_SUB = 9'b1_1_0_01_0_0_0_0;
  localparam logic [8:0] W_OR  = 9'b1_1_0_10_0_0_0_0;
  localparam logic [8:0] W_ORI = 9'b0_1_1_10_0_0_0_0;
  localparam logic [8:0] W_LW  = 9'b0_1_1_00_1_1_0_0;
  localparam logic [8:0] W_SW  = 9'b0_0_1_00_1_0_1_0;
  localparam logic [8:0] W_BEQ = 9'b0_0_0_01_0_0_0_1;
  localparam logic [8:0] W_NOP = 9'b0_0_0_00_0_0_0_0;

  function automatic logic [8:0] model(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'b000000: case (fn)
                   6'b100000: return W_ADD;
                   6'b100010: return W_SUB;
                   6'b100101: return W_OR;
                   default:   return W_NOP;
                 endcase
      6'b001101: return W_ORI;
      6'b100011: return W_LW;
      6'b101011: return W_SW;
      6'b000100: return W_BEQ;
      default:   return W_NOP;
    endcase
  endfunction

  task automatic apply_check(input string req, input logic [5:0] op,
                             input logic [5:0] fn, input logic [8:0] exp);
    @(negedge clk);
    instr_op = op;
    instr_fn = fn;
    #2;
    n_cmp++;
    if (actual_word() !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, op, fn, actual_word(), exp);
    end
    n_cmp++;
    if (reg_we && mem_we) begin
      n_bad++;
      $display("FAIL R10 op=%b fn=%b actual we=%b%b expected not both", op, fn, reg_we, mem_we);
    end
  endtask

  task automatic t_reset_state();
    apply_check("R8 reset", 6'b000000, 6'b000000, W_NOP);
  endtask

  task automatic t_reg_ops();
    apply_check("R1", 6'b000000, 6'b100000, W_ADD);
    apply_check("R2", 6'b000000, 6'b100010, W_SUB);
    apply_check("R3", 6'b000000, 6'b100101, W_OR);
    apply_check("R1", 6'b000000, 6'b100000, W_ADD);
  endtask

  task automatic t_imm_or();   apply_check("R4", 6'b001101, 6'b100010, W_ORI); endtask
  task automatic t_load();     apply_check("R5", 6'b100011, 6'b000000, W_LW);  endtask
  task automatic t_store();    apply_check("R6", 6'b101011, 6'b111111, W_SW);  endtask
  task automatic t_branch();   apply_check("R7", 6'b000100, 6'b100000, W_BEQ); endtask

  task automatic t_unknown();
    for (int f = 0; f < 64; f++)
      apply_check("R8 funct", 6'b000000, 6'(f), model(6'b000000, 6'(f)));
    for (int o = 1; o < 64; o++)
      apply_check("R8 opcode", 6'(o), 6'b100000, model(6'(o), 6'b100000));
  endtask

  task automatic t_funct_ignored();
    for (int o = 1; o < 64; o++)
      for (int f = 0; f < 64; f++)
        apply_check("R9", 6'(o), 6'(f), model(6'(o), 6'b000000));
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    instr_op = '0;
    instr_fn = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_reg_ops();
    t_imm_or();
    t_load();
    t_store();
    t_branch();
    t_unknown();
    t_funct_ignored();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule